// File: doc/BRIEF.md
# Parallel-Index Physically-Tagged L1 Lookup

This block is the lookup stage of a level-one data cache whose set is chosen while the address is still virtual. The requester presents the untranslated page-offset part of the address. Those bits never change under translation, so the block can latch the set and word position at once. In the following cycle the translation unit supplies the physical frame number. That frame is compared against the stored physical tags of every way in the chosen set. The answer is one of four outcomes: a hit with the selected 64-bit word, a miss, a stall because translation had no entry, or a fault because translation refused the access.

Line fills arrive on a single-cycle write port that carries the set, the physical frame and the whole line. The block picks the victim way itself. An empty way is taken first. When the set is full, a per-set binary pseudo-LRU tree chooses the way, and both hits and fills update that tree. The geometry must keep the number of sets times the line size within one page, so the index never depends on translated bits. With the defaults (64 sets, 64-byte lines, 4 KB page) this uses exactly the full page offset. Raising the way count to 8 gives 32 KB of capacity.

Top module: `vipt_l1_lookup`

## Requirements
- R1: The request carries address bits 11:3 as `req_idx`. Bits 8:3 of `req_idx` (address bits 11:6) select the set and bits 2:0 (address bits 5:3) select the 64-bit word in the line. `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high.
- R2: When the translation reports neither a miss nor a fault and a valid way of the set holds a tag equal to `xlat_pfn`, `rsp_hit` is high, `rsp_way` gives that way, and `rsp_word` is word `req_idx[2:0]` of that way's line, where word k is `fill_line[64k+63:64k]`. `rsp_word` is zero whenever `rsp_hit` is low.
- R3: When translation succeeds but no valid way matches, `rsp_miss` is high. Exactly one of hit, miss, stall and fault is high in every cycle with `rsp_valid`, and none of them is high otherwise.
- R4: When `xlat_miss` is high and `xlat_fault` is low, `rsp_stall` is high and neither hit nor miss is reported, even if a tag matches.
- R5: When `xlat_fault` is high, `rsp_fault` is high and no hit, miss or stall is reported, whatever `xlat_miss` and the tags hold.
- R6: A fill writes the lowest-numbered invalid way of `fill_set` if one exists. `fill_way` shows the chosen way in the fill cycle, and the line hits from the next lookup on.
- R7: In a full set the victim follows a tree of WAYS-1 bits per set. Starting at the root, each node bit gives the older half (0 = lower-numbered half), and the bits taken form the way number from its most significant bit down. A hit or a fill points every node on the used way's path at the other half. All trees are zero after reset.
- R8: Reset invalidates every way, so every successfully translated lookup after reset is a miss. All response outputs are low during and right after reset.
- R9: A fill changes only the chosen way of the chosen set. Lines in other ways and other sets keep their data and keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_idx | input | 9 | Virtual address bits 11:3 (set and word) |
| xlat_pfn | input | 28 | Physical frame from translation, cycle after request |
| xlat_miss | input | 1 | Translation had no entry |
| xlat_fault | input | 1 | Translation denied the access |
| fill_valid | input | 1 | Install a line |
| fill_set | input | 6 | Set of the line to install |
| fill_pfn | input | 28 | Physical tag of the line to install |
| fill_line | input | 512 | Line data, word k in bits 64k+63:64k |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Tag matched with good translation |
| rsp_miss | output | 1 | No tag matched with good translation |
| rsp_stall | output | 1 | Translation missing |
| rsp_fault | output | 1 | Translation faulted |
| rsp_way | output | 2 | Way that hit |
| rsp_word | output | 64 | Selected word on a hit, else zero |
| fill_way | output | 2 | Victim way for the current fill |

## Verification
The properties assume that a line is never installed while the same physical frame already sits valid in that set, so at most one way can match. They also assume `req_valid` stays low while reset is held, and that the translation inputs belong to the cycle after the request. The stimulus meets the first assumption by issuing a fill only after its own model reports a miss for that set and frame. It holds requests low during reset, and it drives translation only in the response cycle. Random lookups are spread over a few sets and a small pool of frames, so sets fill up, replacement runs often, and stalls and faults often land on lines that would otherwise hit.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_MISS  = 2'd1,
    RES_STALL = 2'd2,
    RES_FAULT = 2'd3
  } lookup_res_e;

  // Outcome of a lookup: a translation fault outranks a missing translation,
  // and both outrank the tag comparison.
  function automatic lookup_res_e classify(input logic fault, input logic tlb_miss,
                                           input logic tag_match);
    if (fault)          return RES_FAULT;
    else if (tlb_miss)  return RES_STALL;
    else if (tag_match) return RES_HIT;
    else                return RES_MISS;
  endfunction

endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int PFN_W = 28,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [PFN_W-1:0] cmp_pfn,
  output logic [WAYS-1:0]  match_vec,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [PFN_W-1:0] wr_pfn,
  output logic [WAYS-1:0]  wr_set_vld
);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [PFN_W-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_pfn;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      match_vec[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == cmp_pfn);
  end

  assign wr_set_vld = vld_q[wr_set];

endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
  parameter int WAYS      = 4,
  parameter int SETS      = 64,
  parameter int WPL       = 8,
  parameter int WORD_BITS = 64,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(WPL),
  localparam int LINE_BITS = WPL * WORD_BITS
) (
  input  logic                 clk,
  input  logic [SET_W-1:0]     rd_set,
  input  logic [WAY_W-1:0]     rd_way,
  input  logic [WSEL_W-1:0]    rd_word,
  output logic [WORD_BITS-1:0] rd_data,
  input  logic                 wr_en,
  input  logic [SET_W-1:0]     wr_set,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [LINE_BITS-1:0] wr_line
);

  logic [WORD_BITS-1:0] mem_q [SETS][WAYS][WPL];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < WPL; k++)
        mem_q[wr_set][wr_way][k] <= wr_line[k*WORD_BITS +: WORD_BITS];
    end
  end

  assign rd_data = mem_q[rd_set][rd_way][rd_word];

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TREE_W = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAYS-1:0]  fill_set_vld,
  output logic [WAY_W-1:0] victim
);

  logic [TREE_W-1:0] tree_q [SETS];
  logic [TREE_W-1:0] tree_d [SETS];

  // Point every node on the path of way w at the opposite half.
  function automatic logic [TREE_W-1:0] plru_touch(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0]  w);
    logic [TREE_W-1:0] r;
    int node;
    r = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      r[node] = ~w[WAY_W-1-l];
      node = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  // Follow the node bits from the root toward the older half.
  function automatic logic [WAY_W-1:0] plru_pick(input logic [TREE_W-1:0] t);
    logic [WAY_W-1:0] v;
    int node;
    v = '0;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      v[WAY_W-1-l] = t[node];
      node = 2 * node + 1 + int'(t[node]);
    end
    return v;
  endfunction

  logic             inv_found;
  logic [WAY_W-1:0] inv_way;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!fill_set_vld[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  assign victim = inv_found ? inv_way : plru_pick(tree_q[fill_set]);

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      tree_d[s] = tree_q[s];
      if (hit_en && hit_set == SET_W'(s))   tree_d[s] = plru_touch(tree_d[s], hit_way);
      if (fill_en && fill_set == SET_W'(s)) tree_d[s] = plru_touch(tree_d[s], victim);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= tree_d[s];
    end
  end

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BITS  = 12,
  parameter int PFN_W      = 28,
  parameter int WORD_BITS  = 64,
  localparam int SET_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int WPL       = (LINE_BYTES * 8) / WORD_BITS,
  localparam int WSEL_W    = $clog2(WPL),
  localparam int IDX_W     = SET_W + WSEL_W,
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_idx,
  input  logic [PFN_W-1:0]     xlat_pfn,
  input  logic                 xlat_miss,
  input  logic                 xlat_fault,
  input  logic                 fill_valid,
  input  logic [SET_W-1:0]     fill_set,
  input  logic [PFN_W-1:0]     fill_pfn,
  input  logic [LINE_BITS-1:0] fill_line,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_stall,
  output logic                 rsp_fault,
  output logic [WAY_W-1:0]     rsp_way,
  output logic [WORD_BITS-1:0] rsp_word,
  output logic [WAY_W-1:0]     fill_way
);

  // The set index must lie entirely inside the untranslated page offset.
  if (SETS * LINE_BYTES > (1 << PAGE_BITS)) begin : g_geom_bad
    $error("cache geometry exceeds one page");
  end

  function automatic logic [WAY_W-1:0] onehot_idx(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  // Stage 1: index latched from virtual bits while translation runs.
  logic              s1_valid;
  logic [SET_W-1:0]  s1_set;
  logic [WSEL_W-1:0] s1_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_set   <= '0;
      s1_word  <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_set  <= req_idx[IDX_W-1:WSEL_W];
        s1_word <= req_idx[WSEL_W-1:0];
      end
    end
  end

  // Named internal events for the checker.
  logic [WAYS-1:0]      match_vec;
  logic [WAYS-1:0]      fill_set_vld;
  logic [WAY_W-1:0]     hit_way;
  logic [WORD_BITS-1:0] rd_data;
  lookup_res_e          res;

  vipt_tag_array #(.WAYS(WAYS), .SETS(SETS), .PFN_W(PFN_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_set     (s1_set),
    .cmp_pfn    (xlat_pfn),
    .match_vec  (match_vec),
    .wr_en      (fill_valid),
    .wr_set     (fill_set),
    .wr_way     (fill_way),
    .wr_pfn     (fill_pfn),
    .wr_set_vld (fill_set_vld)
  );

  vipt_data_array #(.WAYS(WAYS), .SETS(SETS), .WPL(WPL), .WORD_BITS(WORD_BITS)) u_data (
    .clk     (clk),
    .rd_set  (s1_set),
    .rd_way  (hit_way),
    .rd_word (s1_word),
    .rd_data (rd_data),
    .wr_en   (fill_valid),
    .wr_set  (fill_set),
    .wr_way  (fill_way),
    .wr_line (fill_line)
  );

  assign hit_way = onehot_idx(match_vec);
  assign res     = classify(xlat_fault, xlat_miss, |match_vec);

  assign rsp_valid = s1_valid;
  assign rsp_hit   = s1_valid && (res == RES_HIT);
  assign rsp_miss  = s1_valid && (res == RES_MISS);
  assign rsp_stall = s1_valid && (res == RES_STALL);
  assign rsp_fault = s1_valid && (res == RES_FAULT);
  assign rsp_way   = hit_way;
  assign rsp_word  = rsp_hit ? rd_data : '0;

  vipt_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_en       (rsp_hit),
    .hit_set      (s1_set),
    .hit_way      (hit_way),
    .fill_en      (fill_valid),
    .fill_set     (fill_set),
    .fill_set_vld (fill_set_vld),
    .victim       (fill_way)
  );

endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_stall,
  input logic             rsp_fault,
  input logic             xlat_miss,
  input logic             xlat_fault,
  input logic [WAYS-1:0]  match_vec,
  input logic             fill_valid,
  input logic [WAY_W-1:0] fill_way,
  input logic [WAYS-1:0]  fill_set_vld
);

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_stall, rsp_fault}) == 1);

  // R2
  hit_needs_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (!xlat_miss && !xlat_fault && (match_vec != '0)));

  // R4
  stall_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && xlat_miss && !xlat_fault) |-> (rsp_stall && !rsp_hit && !rsp_miss));

  // R5
  fault_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && xlat_fault) |-> (rsp_fault && !rsp_hit && !rsp_stall));

  // R2
  single_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R6
  fill_takes_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(&fill_set_vld)) |-> !fill_set_vld[fill_way]);

endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.WAYS(WAYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_stall    (rsp_stall),
  .rsp_fault    (rsp_fault),
  .xlat_miss    (xlat_miss),
  .xlat_fault   (xlat_fault),
  .match_vec    (match_vec),
  .fill_valid   (fill_valid),
  .fill_way     (fill_way),
  .fill_set_vld (fill_set_vld)
);

// File: tb/vipt_l1_lookup_tb.sv
module vipt_l1_lookup_tb;

  localparam int NW = 4, NS = 64, NK = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [8:0]   req_idx = '0;
  logic [27:0]  xlat_pfn = '0;
  logic         xlat_miss = 1'b0, xlat_fault = 1'b0;
  logic         fill_valid = 1'b0;
  logic [5:0]   fill_set = '0;
  logic [27:0]  fill_pfn = '0;
  logic [511:0] fill_line = '0;
  logic         rsp_valid, rsp_hit, rsp_miss, rsp_stall, rsp_fault;
  logic [1:0]   rsp_way, fill_way;
  logic [63:0]  rsp_word;

  always #10 clk = ~clk;

  vipt_l1_lookup u_dut (.*);

  int checks = 0, errors = 0;

  // Reference state.
  bit          m_vld  [NS][NW];
  logic [27:0] m_tag  [NS][NW];
  logic [63:0] m_data [NS][NW][NK];
  bit          m_node [NS][NW-1];   // level l, prefix p at (2**l - 1 + p)

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_victim(input int s);
    int p;
    for (int w = 0; w < NW; w++) if (!m_vld[s][w]) return w;
    p = 0;
    for (int l = 0; l < 2; l++) p = 2 * p + int'(m_node[s][(1 << l) - 1 + p]);
    return p;
  endfunction

  function automatic void m_use(input int s, input int w);
    for (int l = 0; l < 2; l++) begin
      int p = w >> (2 - l);          // prefix above this level
      int b = (w >> (1 - l)) & 1;    // side taken at this level
      m_node[s][(1 << l) - 1 + p] = (b == 0);
    end
  endfunction

  task automatic lookup(input int s, input int k, input logic [27:0] pfn,
                        input bit tm, input bit tf, output bit was_miss);
    int hw;
    bit eh, em, es, ef;
    hw = -1;
    for (int w = 0; w < NW; w++) if (m_vld[s][w] && m_tag[s][w] == pfn) hw = w;
    ef = tf;
    es = !tf && tm;
    eh = !tf && !tm && hw >= 0;
    em = !tf && !tm && hw < 0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "idle rsp_valid", 64'(rsp_valid), 0);
    req_valid = 1'b1;
    req_idx = {s[5:0], k[2:0]};
    xlat_pfn = $urandom; xlat_miss = 1'b0; xlat_fault = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    xlat_pfn = pfn; xlat_miss = tm; xlat_fault = tf;
    #1;
    chk(rsp_valid == 1'b1, "R1", "rsp_valid", 64'(rsp_valid), 1);
    chk(rsp_hit == eh, "R2", "hit", 64'(rsp_hit), 64'(eh));
    chk(rsp_miss == em, "R3", "miss", 64'(rsp_miss), 64'(em));
    chk(rsp_stall == es, "R4", "stall", 64'(rsp_stall), 64'(es));
    chk(rsp_fault == ef, "R5", "fault", 64'(rsp_fault), 64'(ef));
    if (eh) begin
      chk(rsp_way == 2'(hw), "R2", "way", 64'(rsp_way), 64'(hw));
      chk(rsp_word == m_data[s][hw][k], "R9", "word", rsp_word, m_data[s][hw][k]);
      m_use(s, hw);
    end else begin
      chk(rsp_word == 64'd0, "R2", "word when no hit", rsp_word, 0);
    end
    was_miss = em;
  endtask

  task automatic fill(input int s, input logic [27:0] pfn, input string req);
    int v;
    v = m_victim(s);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = s[5:0]; fill_pfn = pfn;
    for (int k = 0; k < NK; k++) fill_line[k*64 +: 64] = {$urandom, $urandom};
    #1;
    chk(fill_way == 2'(v), req, "fill_way", 64'(fill_way), 64'(v));
    m_vld[s][v] = 1'b1;
    m_tag[s][v] = pfn;
    for (int k = 0; k < NK; k++) m_data[s][v][k] = fill_line[k*64 +: 64];
    m_use(s, v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit mi;
    void'($urandom(32'd2024));
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) m_vld[s][w] = 1'b0;
      for (int n = 0; n < NW - 1; n++) m_node[s][n] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk(rsp_valid == 1'b0, "R8", "reset rsp_valid", 64'(rsp_valid), 0);
    chk({rsp_hit, rsp_miss, rsp_stall, rsp_fault} == 4'b0, "R8", "reset outcomes",
        64'({rsp_hit, rsp_miss, rsp_stall, rsp_fault}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "post-reset rsp_valid", 64'(rsp_valid), 0);

    // R8: empty cache misses
    lookup(5, 0, 28'h00AA, 0, 0, mi);
    chk(mi, "R8", "miss after reset", 64'(mi), 1);
    // R6: first fill goes to way 0
    fill(5, 28'h00AA, "R6");
    // R1/R2: every word position of the line
    for (int k = 0; k < NK; k++) lookup(5, k, 28'h00AA, 0, 0, mi);
    // R3: same offset, other frame
    lookup(5, 2, 28'h00BB, 0, 0, mi);
    // R1: other set, same frame
    lookup(6, 2, 28'h00AA, 0, 0, mi);
    // R4 / R5: translation trouble on a matching tag
    lookup(5, 3, 28'h00AA, 1, 0, mi);
    lookup(5, 3, 28'h00AA, 0, 1, mi);
    lookup(5, 3, 28'h00AA, 1, 1, mi);
    // R6: empty ways in order, then R7 replacement
    fill(5, 28'h00BB, "R6");
    fill(5, 28'h00CC, "R6");
    fill(5, 28'h00DD, "R6");
    lookup(5, 1, 28'h00AA, 0, 0, mi);
    fill(5, 28'h00EE, "R7");
    fill(5, 28'h00FF, "R7");
    // R9: survivors still hit with their own data
    for (int f = 0; f < 6; f++) lookup(5, f, 28'h00AA + 28'(f) * 28'h11, 0, 0, mi);

    // Random traffic over a few sets and a small frame pool (R7, R9).
    for (int i = 0; i < 700; i++) begin
      int s = 8 + int'($urandom % 4);
      int k = int'($urandom % NK);
      logic [27:0] pfn = 28'h100 + 28'($urandom % 7);
      bit tm = ($urandom % 10) == 0;
      bit tf = ($urandom % 12) == 0;
      lookup(s, k, pfn, tm, tf, mi);
      if (mi) fill(s, pfn, "R7");
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule